// File: doc/BRIEF.md
# Mode-Configurable Transmit Character Serializer

This block takes one character at a time from a parallel host bus (ten data bits, four command bits and a data/command select line) and sends it out one bit per clock on a single serial line. Two static mode inputs select the character format. An encoder-bypass input and a byte-width input together choose one of four formats. Two formats pass a pre-encoded character straight through, one with 10 bits and one with 12 bits. The third encodes an 8-bit byte as two 4B/5B symbols. The fourth setting, the encoded 10-bit format, is not supported: the block refuses characters and raises an error while it is selected.

The host offers a character by raising `tx_en`. The character is captured on a rising clock edge while `ready` is high. `ready` is high whenever the line is sending fill, and on the last bit of a character. A continuously offered stream therefore leaves the block with no gap between characters. When nothing is offered, the block repeats an alternating fill pattern whose length follows the active format. A copy of `ready` is also brought out as `status_flag`, and a configuration input sets the polarity of that copy.

The controller has three states:
- `S_FILL` sends the fill pattern.
- `S_SEND` sends a captured character.
- `S_ERR` holds the line low while the format is unsupported.

Transitions:
- `S_FILL` to `S_SEND` on a capture.
- `S_FILL` to `S_FILL`, restarting the fill frame at its last bit.
- `S_FILL` to `S_ERR` when the format is unsupported and no capture happens.
- `S_SEND` to `S_SEND` on a back-to-back capture at the last bit.
- `S_SEND` to `S_FILL` at the last bit with nothing offered.
- `S_SEND` to `S_ERR` at the last bit when the format has become unsupported.
- `S_ERR` to `S_FILL` once the format is supported again.

Top module: `tx_char_serializer`

## Requirements
- R1: A character is captured only on a rising edge where both `tx_en` and `ready` are high. Its first bit appears on `ser_out` in the clock cycle after that edge. While `tx_en` is low, changes on the host bus do not disturb the line.
- R2: Pre-encoded 10-bit format (`mode_bypass`=1, `mode_byte8`=1): the block sends `tx_data[0]` first, then ascending bits through `tx_data[9]`. The command bus and the select line are ignored.
- R3: Pre-encoded 12-bit format (`mode_bypass`=1, `mode_byte8`=0): character bits 0 to 9 are `tx_data[9:0]`, bit 10 is `tx_cmd[1]` and bit 11 is `tx_cmd[0]`. The send order is bits 0 to 9 ascending, then bit 11, then bit 10. The line therefore carries `tx_cmd[0]` before `tx_cmd[1]`.
- R4: Encoded 8-bit format (`mode_bypass`=0, `mode_byte8`=1) with `tx_sel_cmd`=0: the block sends the 5-bit symbol of `tx_data[7:4]`, then the symbol of `tx_data[3:0]`. Each symbol is sent MSB first, so one character takes 10 bit times. The symbol table for nibbles 0 to F is 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R5: In the encoded 8-bit format with `tx_sel_cmd`=1, the second symbol comes from `tx_cmd`. Command value n maps to the n-th smallest (counting from zero) of the sixteen 5-bit codes that are absent from the R4 table. The first symbol is still taken from `tx_data[7:4]`.
- R6: `ready` is high only when the format is supported and the block is either sending fill or on the last bit of a character. It is low on every other bit of a character. A character offered on that last bit is sent with no gap.
- R7: When no character is pending, `ser_out` repeats the pattern 1,0,1,0,… in frames of 10 bits (12 bits in the 12-bit format). The first fill frame starts in the cycle after the last character bit.
- R8: A change of the mode inputs while a character is being sent does not alter that character. The new format applies from the next capture or fill frame.
- R9: While the unsupported setting (`mode_bypass`=0, `mode_byte8`=0) is applied, `ready` is low and no character is captured. Unless a character is still being sent, `mode_err` goes high one cycle later and `ser_out` stays low. The cycle after a supported setting returns, `mode_err` is low and fill resumes with a 1.
- R10: `status_flag` equals `ready` when `flag_active_low` is 0 and is its inverse when `flag_active_low` is 1.
- R11: In the first cycle after reset is released, `ser_out` and `mode_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Host offers a character |
| tx_data | input | 10 | Host data bits |
| tx_cmd | input | 4 | Host command bits |
| tx_sel_cmd | input | 1 | Selects the command nibble as the second symbol in the encoded format |
| mode_bypass | input | 1 | Encoder bypass: 1 selects a pre-encoded format |
| mode_byte8 | input | 1 | Width select: 1 selects a 10-bit line character |
| flag_active_low | input | 1 | Polarity of `status_flag` |
| ser_out | output | 1 | Serial line |
| ready | output | 1 | Block will capture an offered character at the next edge |
| status_flag | output | 1 | `ready` in the configured polarity |
| mode_err | output | 1 | Unsupported format is selected |

## Verification
The last bit of one character and the capture of the next can fall in the same cycle. So can a capture and a mode change. In both cases the shifter must finish the old frame while the controller loads a new one. The bench provokes the first case by keeping `tx_en` high and presenting a second character mid-frame. It judges the result by checking that `ready` stays low until exactly the last bit, and that the twenty sampled line bits equal both expected frames joined together. It provokes the second case by switching the mode inputs in the middle of a 12-bit character. It then checks that the character keeps its 12-bit order and that the fill which follows takes the new 10-bit length.

// File: rtl/tx_ser_pkg.sv
package tx_ser_pkg;

    localparam int DATA_W    = 10;
    localparam int CMD_W     = 4;
    localparam int NIB_W     = 4;
    localparam int SYM_W     = 5;
    localparam int FRAME_W   = 12;
    localparam int SHORT_LEN = 10;
    localparam int LONG_LEN  = 12;
    localparam int CNT_W     = $clog2(LONG_LEN);

    typedef enum logic [1:0] {
        S_FILL = 2'd0,
        S_SEND = 2'd1,
        S_ERR  = 2'd2
    } ser_state_t;

    // {bypass, byte8}
    typedef enum logic [1:0] {
        FMT_ENC10 = 2'b00,
        FMT_ENC8  = 2'b01,
        FMT_PRE12 = 2'b10,
        FMT_PRE10 = 2'b11
    } char_fmt_t;

    function automatic logic [SYM_W-1:0] sym_data(input logic [NIB_W-1:0] nib);
        logic [SYM_W-1:0] s;
        unique case (nib)
            4'h0: s = 5'b11110;
            4'h1: s = 5'b01001;
            4'h2: s = 5'b10100;
            4'h3: s = 5'b10101;
            4'h4: s = 5'b01010;
            4'h5: s = 5'b01011;
            4'h6: s = 5'b01110;
            4'h7: s = 5'b01111;
            4'h8: s = 5'b10010;
            4'h9: s = 5'b10011;
            4'hA: s = 5'b10110;
            4'hB: s = 5'b10111;
            4'hC: s = 5'b11010;
            4'hD: s = 5'b11011;
            4'hE: s = 5'b11100;
            default: s = 5'b11101;
        endcase
        return s;
    endfunction

    // control symbols: the sixteen codes outside the data table, ascending
    function automatic logic [SYM_W-1:0] sym_ctrl(input logic [NIB_W-1:0] nib);
        logic [SYM_W-1:0] s;
        unique case (nib)
            4'h0: s = 5'b00000;
            4'h1: s = 5'b00001;
            4'h2: s = 5'b00010;
            4'h3: s = 5'b00011;
            4'h4: s = 5'b00100;
            4'h5: s = 5'b00101;
            4'h6: s = 5'b00110;
            4'h7: s = 5'b00111;
            4'h8: s = 5'b01000;
            4'h9: s = 5'b01100;
            4'hA: s = 5'b01101;
            4'hB: s = 5'b10000;
            4'hC: s = 5'b10001;
            4'hD: s = 5'b11000;
            4'hE: s = 5'b11001;
            default: s = 5'b11111;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tx_char_format.sv
module tx_char_format
    import tx_ser_pkg::*;
(
    input  logic [1:0]         fmt,
    input  logic [DATA_W-1:0]  data,
    input  logic [CMD_W-1:0]   cmd,
    input  logic               sel_cmd,
    output logic [FRAME_W-1:0] frame,
    output logic               long_char,
    output logic               fmt_ok
);

    logic [SYM_W-1:0] sym_hi;
    logic [SYM_W-1:0] sym_lo;

    assign sym_hi = sym_data(data[2*NIB_W-1:NIB_W]);
    assign sym_lo = sel_cmd ? sym_ctrl(cmd) : sym_data(data[NIB_W-1:0]);

    // frame[0] is the first bit on the line
    always_comb begin
        frame     = '0;
        long_char = 1'b0;
        fmt_ok    = 1'b1;
        unique case (char_fmt_t'(fmt))
            FMT_PRE10: begin
                frame = {2'b00, data};
            end
            FMT_PRE12: begin
                frame     = {cmd[1], cmd[0], data};
                long_char = 1'b1;
            end
            FMT_ENC8: begin
                for (int i = 0; i < SYM_W; i++) begin
                    frame[i]         = sym_hi[SYM_W-1-i];
                    frame[SYM_W + i] = sym_lo[SYM_W-1-i];
                end
            end
            default: begin
                fmt_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tx_shift_fsm.sv
module tx_shift_fsm
    import tx_ser_pkg::*;
#(
    parameter logic [FRAME_W-1:0] IDLE_PATTERN = 12'h555
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_en,
    input  logic               fmt_ok,
    input  logic [FRAME_W-1:0] frame,
    input  logic               long_char,
    output logic               ser_out,
    output logic               ready,
    output logic               fmt_err
);

    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_LEN - 1);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_LEN - 1);

    ser_state_t         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [CNT_W-1:0]   last_q, last_d;
    logic [FRAME_W-1:0] sreg_q, sreg_d;
    logic               at_last;
    logic               take;
    logic [CNT_W-1:0]   sel_last;

    assign at_last  = (cnt_q == last_q);
    assign sel_last = long_char ? LAST_LONG : LAST_SHORT;
    assign take     = tx_en && ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_FILL;
            cnt_q   <= '0;
            last_q  <= '0;
            sreg_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            last_q  <= last_d;
            sreg_q  <= sreg_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + CNT_W'(1);
        last_d  = last_q;
        sreg_d  = sreg_q >> 1;
        unique case (state_q)
            S_FILL: begin
                if (take) begin
                    state_d = S_SEND;
                    sreg_d  = frame;
                    cnt_d   = '0;
                    last_d  = sel_last;
                end else if (!fmt_ok) begin
                    state_d = S_ERR;
                    sreg_d  = '0;
                    cnt_d   = '0;
                end else if (at_last) begin
                    sreg_d = IDLE_PATTERN;
                    cnt_d  = '0;
                    last_d = sel_last;
                end
            end
            S_SEND: begin
                if (at_last) begin
                    cnt_d  = '0;
                    last_d = sel_last;
                    if (take) begin
                        sreg_d = frame;
                    end else if (!fmt_ok) begin
                        state_d = S_ERR;
                        sreg_d  = '0;
                    end else begin
                        state_d = S_FILL;
                        sreg_d  = IDLE_PATTERN;
                    end
                end
            end
            S_ERR: begin
                cnt_d  = '0;
                sreg_d = '0;
                if (fmt_ok) begin
                    state_d = S_FILL;
                    sreg_d  = IDLE_PATTERN;
                    last_d  = sel_last;
                end
            end
            default: begin
                state_d = S_FILL;
                cnt_d   = '0;
                last_d  = '0;
                sreg_d  = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        ser_out = sreg_q[0];
        fmt_err = (state_q == S_ERR);
        ready   = fmt_ok && ((state_q == S_FILL) || ((state_q == S_SEND) && at_last));
    end

endmodule

// File: rtl/tx_char_serializer.sv
module tx_char_serializer
    import tx_ser_pkg::*;
#(
    parameter logic [FRAME_W-1:0] IDLE_PATTERN = 12'h555
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [CMD_W-1:0]  tx_cmd,
    input  logic              tx_sel_cmd,
    input  logic              mode_bypass,
    input  logic              mode_byte8,
    input  logic              flag_active_low,
    output logic              ser_out,
    output logic              ready,
    output logic              status_flag,
    output logic              mode_err
);

    logic [FRAME_W-1:0] frame;
    logic               long_char;
    logic               fmt_ok;

    tx_char_format u_format (
        .fmt       ({mode_bypass, mode_byte8}),
        .data      (tx_data),
        .cmd       (tx_cmd),
        .sel_cmd   (tx_sel_cmd),
        .frame     (frame),
        .long_char (long_char),
        .fmt_ok    (fmt_ok)
    );

    tx_shift_fsm #(
        .IDLE_PATTERN (IDLE_PATTERN)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .fmt_ok    (fmt_ok),
        .frame     (frame),
        .long_char (long_char),
        .ser_out   (ser_out),
        .ready     (ready),
        .fmt_err   (mode_err)
    );

    assign status_flag = ready ^ flag_active_low;

endmodule

// File: rtl/tx_char_serializer_chk.sv
module tx_char_serializer_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic mode_bypass,
    input logic mode_byte8,
    input logic ser_out,
    input logic ready,
    input logic mode_err
);

    // R6: a capture is followed by a busy bit
    p_busy_after_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && ready) |=> !ready);

    // R9: error state never offers a capture
    p_err_blocks_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> !ready);

    // R9: line held low in error state
    p_err_line_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> !ser_out);

    // R9: error only follows the unsupported setting
    p_err_from_bad_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_err) |-> $past(!mode_bypass && !mode_byte8));

    // R9: unsupported setting never offers a capture
    p_bad_mode_no_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_bypass && !mode_byte8) |-> !ready);

    // R1: a capture starts a character, not an error
    p_take_no_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && ready) |=> !mode_err);

endmodule

bind tx_char_serializer tx_char_serializer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (tx_en),
    .mode_bypass (mode_bypass),
    .mode_byte8  (mode_byte8),
    .ser_out     (ser_out),
    .ready       (ready),
    .mode_err    (mode_err)
);

// File: tb/tx_char_serializer_tb.sv
module tx_char_serializer_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tx_en;
    logic [9:0] tx_data;
    logic [3:0] tx_cmd;
    logic       tx_sel_cmd;
    logic       mode_bypass;
    logic       mode_byte8;
    logic       flag_active_low;
    logic       ser_out;
    logic       ready;
    logic       status_flag;
    logic       mode_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    tx_char_serializer u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .tx_en           (tx_en),
        .tx_data         (tx_data),
        .tx_cmd          (tx_cmd),
        .tx_sel_cmd      (tx_sel_cmd),
        .mode_bypass     (mode_bypass),
        .mode_byte8      (mode_byte8),
        .flag_active_low (flag_active_low),
        .ser_out         (ser_out),
        .ready           (ready),
        .status_flag     (status_flag),
        .mode_err        (mode_err)
    );

    function automatic logic [4:0] enc_d(input logic [3:0] n);
        logic [4:0] t [16];
        t = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011, 5'b01110, 5'b01111,
              5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    function automatic logic [4:0] enc_c(input logic [3:0] n);
        int idx = 0;
        for (int v = 0; v < 32; v++) begin
            bit in_tab = 0;
            for (int d = 0; d < 16; d++)
                if (enc_d(4'(d)) == 5'(v)) in_tab = 1;
            if (!in_tab) begin
                if (idx == int'(n)) return 5'(v);
                idx++;
            end
        end
        return 5'b0;
    endfunction

    function automatic int exp_len(input logic [1:0] m);
        return (m == 2'b10) ? 12 : 10;
    endfunction

    // bit k = k-th bit on the line
    function automatic logic [11:0] exp_bits(input logic [1:0] m, input logic [9:0] d,
                                             input logic [3:0] c, input logic s);
        logic [11:0] r = '0;
        logic [4:0]  hi, lo;
        if (m == 2'b11) begin
            for (int k = 0; k < 10; k++) r[k] = d[k];
        end else if (m == 2'b10) begin
            for (int k = 0; k < 10; k++) r[k] = d[k];
            r[10] = c[0];
            r[11] = c[1];
        end else begin
            hi = enc_d(d[7:4]);
            lo = s ? enc_c(c) : enc_d(d[3:0]);
            for (int k = 0; k < 5; k++) begin
                r[k]     = hi[4-k];
                r[5 + k] = lo[4-k];
            end
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_char(input logic [1:0] m, input logic [9:0] d,
                            input logic [3:0] c, input logic s);
        {mode_bypass, mode_byte8} = m;
        tx_data    = d;
        tx_cmd     = c;
        tx_sel_cmd = s;
    endtask

    task automatic wait_ready();
        int guard = 0;
        #1;
        while (!ready && guard < 50) begin
            @(negedge clk);
            #1;
            guard++;
        end
    endtask

    // offers one character, returns at the negedge of its last bit
    task automatic send_one(input logic [1:0] m, input logic [9:0] d, input logic [3:0] c,
                            input logic s, input string req);
        logic [11:0] got = '0;
        logic [11:0] exp;
        int          len;
        bit          busy_ok = 1;
        @(negedge clk);
        set_char(m, d, c, s);
        tx_en = 1'b1;
        wait_ready();
        @(posedge clk);
        @(negedge clk);
        tx_en = 1'b0;
        len = exp_len(m);
        exp = exp_bits(m, d, c, s);
        for (int k = 0; k < len; k++) begin
            #1;
            got[k] = ser_out;
            if (k < len - 1 && ready) busy_ok = 0;
            if (k < len - 1) @(negedge clk);
        end
        check(got == exp, req, 32'(got), 32'(exp));
        check(busy_ok, "R6 busy", 32'(busy_ok), 32'd1);
    endtask

    task automatic check_idle(input int len, input string req);
        logic [11:0] got = '0;
        logic [11:0] exp = '0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            #1;
            got[k] = ser_out;
            exp[k] = ~k[0];
        end
        check(got == exp, req, 32'(got), 32'(exp));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [19:0] got20;
        logic [19:0] exp20;
        logic [11:0] got;
        logic [11:0] exp;
        bit          low_ok;

        rst_n = 1'b0;
        tx_en = 1'b0;
        flag_active_low = 1'b0;
        set_char(2'b11, 10'h0, 4'h0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state, R6 ready in fill, R10 active-high flag
        check({ser_out, mode_err} == 2'b00, "R11 reset", 32'({ser_out, mode_err}), 32'd0);
        check(ready == 1'b1, "R6 ready after reset", 32'(ready), 32'd1);
        check(status_flag == 1'b1, "R10 active high", 32'(status_flag), 32'd1);

        // R4: every byte in the encoded 8-bit format
        for (int d = 0; d < 256; d++)
            send_one(2'b01, 10'(d), 4'(d), 1'b0, "R4 enc8 data");

        // R5: every command nibble
        for (int c = 0; c < 16; c++)
            send_one(2'b01, 10'(37 * c + 5), 4'(c), 1'b1, "R5 enc8 cmd");
        check_idle(10, "R7 fill after enc8");

        // R2: walking ones and patterns, command bus ignored
        for (int i = 0; i < 10; i++)
            send_one(2'b11, 10'(1 << i), 4'hF, 1'b1, "R2 pre10");
        send_one(2'b11, 10'h3FF, 4'h0, 1'b0, "R2 pre10");
        send_one(2'b11, 10'h2AA, 4'hA, 1'b1, "R2 pre10");
        send_one(2'b11, 10'h155, 4'h5, 1'b0, "R2 pre10");

        // R3: walking ones across all 12 character bits
        for (int i = 0; i < 12; i++)
            send_one(2'b10, (i < 10) ? 10'(1 << i) : 10'h0,
                     (i == 10) ? 4'b0010 : ((i == 11) ? 4'b0001 : 4'b1100), 1'b0, "R3 pre12");
        send_one(2'b10, 10'h1C7, 4'b1101, 1'b1, "R3 pre12");
        check_idle(12, "R7 fill after pre12");

        // R1: bus activity without tx_en leaves fill untouched
        set_char(2'b10, 10'h3FF, 4'hF, 1'b1);
        check_idle(12, "R1 no capture without tx_en");
        tx_data = 10'h000;
        check_idle(12, "R1 no capture without tx_en");

        // R6: back-to-back, second character offered mid-frame
        @(negedge clk);
        set_char(2'b11, 10'h2C3, 4'h0, 1'b0);
        tx_en = 1'b1;
        wait_ready();
        @(posedge clk);
        @(negedge clk);
        got20 = '0;
        low_ok = 1;
        for (int k = 0; k < 10; k++) begin
            if (k == 2) tx_data = 10'h0F1;
            #1;
            got20[k] = ser_out;
            if (k < 9 && ready) low_ok = 0;
            if (k == 9) check(ready == 1'b1, "R6 ready on last bit", 32'(ready), 32'd1);
            @(negedge clk);
        end
        tx_en = 1'b0;
        for (int k = 10; k < 20; k++) begin
            #1;
            got20[k] = ser_out;
            if (k < 19) @(negedge clk);
        end
        exp20 = {exp_bits(2'b11, 10'h0F1, 4'h0, 1'b0)[9:0], exp_bits(2'b11, 10'h2C3, 4'h0, 1'b0)[9:0]};
        check(low_ok, "R6 busy mid-frame", 32'(low_ok), 32'd1);
        check(got20 == exp20, "R6 back-to-back stream", 32'(got20), 32'(exp20));

        // R8: mode change mid-character
        @(negedge clk);
        set_char(2'b10, 10'h1B6, 4'b0001, 1'b0);
        tx_en = 1'b1;
        wait_ready();
        @(posedge clk);
        @(negedge clk);
        tx_en = 1'b0;
        got = '0;
        for (int k = 0; k < 12; k++) begin
            if (k == 3) set_char(2'b11, 10'h3FF, 4'hE, 1'b1);
            #1;
            got[k] = ser_out;
            if (k < 11) @(negedge clk);
        end
        exp = exp_bits(2'b10, 10'h1B6, 4'b0001, 1'b0);
        check(got == exp, "R8 char keeps old format", 32'(got), 32'(exp));
        check_idle(10, "R8 new length in fill");

        // R9: unsupported setting
        @(negedge clk);
        set_char(2'b00, 10'h0AA, 4'h3, 1'b0);
        tx_en = 1'b1;
        #1;
        check(ready == 1'b0, "R9 ready drops", 32'(ready), 32'd0);
        low_ok = 1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            #1;
            if (ser_out || ready || !mode_err) low_ok = 0;
        end
        check(low_ok, "R9 error held, line low", 32'({ser_out, ready, mode_err}), 32'b001);
        @(negedge clk);
        tx_en = 1'b0;
        {mode_bypass, mode_byte8} = 2'b11;
        @(negedge clk);
        #1;
        check({mode_err, ser_out} == 2'b01, "R9 recovery", 32'({mode_err, ser_out}), 32'b01);
        send_one(2'b11, 10'h2B4, 4'h0, 1'b0, "R9 capture after recovery");

        // R10: active-low flag, idle and busy
        @(negedge clk);
        flag_active_low = 1'b1;
        #1;
        check(status_flag == 1'b0, "R10 active low idle", 32'(status_flag), 32'd0);
        set_char(2'b11, 10'h123, 4'h0, 1'b0);
        tx_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_en = 1'b0;
        #1;
        check(status_flag == 1'b1, "R10 active low busy", 32'(status_flag), 32'd1);
        repeat (12) @(negedge clk);

        finish_run();
    end

endmodule